// File: doc/BRIEF.md
# Power-fail write-protect supervisor

This block is a synchronous supervisor placed between a host memory bus and a battery-backed static RAM. Two external comparators report the supply state as digital levels: one says the supply has fallen below the power-fail threshold, the other says it has fallen further, below the battery switchover threshold. Each level is synchronised and deglitched. A five-state machine then decides whether the host may reach the memory, whether writes are blocked, whether the data bus is forced to high impedance and whether storage power is taken from the battery.

On a supply drop, an access that is already running is allowed to finish, but only inside a bounded window. After that window the memory is deselected and write-protected no matter what the host is doing. When the supply returns, protection is held for a long recovery interval before normal access resumes. A new drop during that interval sends the block straight back to protection. The battery is never selected before the supply has been good at least once after reset. All timing limits are parameters counted in clock cycles.

States: NORMAL (host access passes through), GRACE (in-flight access finishing under a deadline), PROTECTED (deselected standby), BATTERY (deselected, storage on battery), RECOVERY (deselected, counting down the lockout). Transitions: NORMAL to GRACE on power-fail with an access active; NORMAL to PROTECTED on power-fail with no access; GRACE to PROTECTED when the access ends or the deadline expires; PROTECTED to BATTERY on switchover once the block is armed; BATTERY to PROTECTED when the supply rises above switchover; PROTECTED to RECOVERY when the power-fail level clears; RECOVERY to NORMAL when the lockout expires; RECOVERY to PROTECTED on a new power-fail.

Top module: `pwr_guard`

## Requirements
- R1: During and just after reset the block is in PROTECTED: wr_prot_o=1, dq_hiz_o=1, mem_ce_n_o=1, bat_sel_o=0.
- R2: Each supply level passes through SYNC_STAGES flops and must then differ from its filtered value for FILT_LEN consecutive cycles before it is accepted. A pulse shorter than FILT_LEN cycles has no effect. An accepted change reaches the outputs SYNC_STAGES+FILT_LEN+1 clock edges after the raw input changes.
- R3: When the power-fail level clears in PROTECTED, the block enters RECOVERY and stays protected for exactly ER_CYCLES cycles. It then enters NORMAL, where wr_prot_o drops to 0.
- R4: A power-fail in NORMAL with acc_act_i=0 moves the block directly to PROTECTED (wr_prot_o=1).
- R5: A power-fail in NORMAL with acc_act_i=1 enters GRACE, where wr_prot_o=0 and mem_ce_n_o follows host_ce_n_i. The first clock edge that samples acc_act_i=0 moves the block to PROTECTED.
- R6: GRACE lasts at most WP_CYCLES cycles. The block then enters PROTECTED even if acc_act_i is still 1.
- R7: In every state other than NORMAL and GRACE, mem_ce_n_o=1, dq_hiz_o=1 and wr_prot_o=1, whatever host_ce_n_i and acc_act_i do.
- R8: In PROTECTED, once armed, an accepted switchover level enters BATTERY (bat_sel_o=1). When that level clears, the block returns to PROTECTED (bat_sel_o=0). A simultaneous drop of both levels from NORMAL reaches BATTERY one edge after PROTECTED.
- R9: Until the power-fail level has been clear at least once after reset, bat_sel_o stays 0 even with the switchover level asserted.
- R10: A power-fail accepted during RECOVERY returns the block to PROTECTED without passing through NORMAL. The next recovery counts a full ER_CYCLES again.
- R11: In NORMAL, mem_ce_n_o equals host_ce_n_i in the same cycle, and wr_prot_o=0, dq_hiz_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vdd_warn_i | input | 1 | Comparator level: supply below power-fail threshold (1 = below) |
| vdd_crit_i | input | 1 | Comparator level: supply below battery switchover threshold (1 = below) |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| acc_act_i | input | 1 | Host access in progress (1 while host holds chip enable low) |
| mem_ce_n_o | output | 1 | Gated chip enable to the memory, active low |
| wr_prot_o | output | 1 | Write protection active |
| dq_hiz_o | output | 1 | Forces the memory data bus to high impedance |
| bat_sel_o | output | 1 | Storage power taken from the battery |

## Verification
The assertions assume that acc_act_i is synchronous to clk and that the switchover level is asserted only while the power-fail level is also asserted, which matches how a falling supply crosses the two thresholds. The comparator levels themselves may glitch freely, because the properties watch the filtered levels. The stimulus drives every input at the falling clock edge. It raises the switchover level only on top of, or together with, the power-fail level, and it randomises pulse widths below the filter length and host enable patterns.

// File: rtl/pwr_guard_pkg.sv
`timescale 1ns/1ps
package pwr_guard_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_GRACE  = 3'd1,
        ST_PROT   = 3'd2,
        ST_BATT   = 3'd3,
        ST_RECOV  = 3'd4
    } pg_state_e;

    // States in which the host still reaches the memory.
    function automatic logic pg_is_open(pg_state_e s);
        return (s == ST_NORMAL) || (s == ST_GRACE);
    endfunction

endpackage

// File: rtl/pwr_guard_deglitch.sv
`timescale 1ns/1ps
module pwr_guard_deglitch #(
    parameter int STAGES  = 2,
    parameter int FILT    = 3,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT - 1);

    logic          sync_s;
    logic [CW-1:0] cnt_q;
    logic          flt_q;

    generate
        if (STAGES <= 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= RST_VAL;
                else        s_q <= raw_i;
            end
            assign sync_s = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= {sh_q[STAGES-2:0], raw_i};
            end
            assign sync_s = sh_q[STAGES-1];
        end
    endgenerate

    // Accept a new level only after FILT consecutive mismatching samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flt_q <= RST_VAL;
        end else if (sync_s != flt_q) begin
            if (cnt_q == LAST) begin
                flt_q <= sync_s;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign flt_o = flt_q;
endmodule

// File: rtl/pwr_guard_tmr.sv
`timescale 1ns/1ps
module pwr_guard_tmr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwr_guard.sv
`timescale 1ns/1ps
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int WP_CYCLES   = 16,
    parameter int ER_CYCLES   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_warn_i,
    input  logic vdd_crit_i,
    input  logic host_ce_n_i,
    input  logic acc_act_i,
    output logic mem_ce_n_o,
    output logic wr_prot_o,
    output logic dq_hiz_o,
    output logic bat_sel_o
);
    localparam int N_SENSE = 2;
    localparam int MAX_T   = (ER_CYCLES > WP_CYCLES) ? ER_CYCLES : WP_CYCLES;
    localparam int CNT_W   = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYCLES - 1);
    localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ER_CYCLES - 1);
    localparam logic [N_SENSE-1:0] SENSE_RST = {N_SENSE{1'b1}};

    logic [N_SENSE-1:0] sense_raw;
    logic [N_SENSE-1:0] sense_flt;
    logic               pf_flt;
    logic               so_flt;

    pg_state_e state_q, state_d;
    logic      armed_q;
    logic      ld_wp, ld_er;
    logic      tmr_zero;
    logic      open_s;

    assign sense_raw = {vdd_crit_i, vdd_warn_i};

    // One deglitch path per comparator level; both reset to "supply low".
    generate
        for (genvar g = 0; g < N_SENSE; g++) begin : g_sense
            pwr_guard_deglitch #(
                .STAGES  (SYNC_STAGES),
                .FILT    (FILT_LEN),
                .RST_VAL (SENSE_RST[g])
            ) u_dg (
                .clk   (clk),
                .rst_n (rst_n),
                .raw_i (sense_raw[g]),
                .flt_o (sense_flt[g])
            );
        end
    endgenerate

    assign pf_flt = sense_flt[0];
    assign so_flt = sense_flt[1];

    pwr_guard_tmr #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_wp | ld_er),
        .load_val (ld_wp ? WP_LOAD : ER_LOAD),
        .expired  (tmr_zero)
    );

    // State register (armed flag records the first good supply).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PROT;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RECOV) armed_q <= 1'b1;
        end
    end

    // Next-state and timer loads.
    always_comb begin
        state_d = state_q;
        ld_wp   = 1'b0;
        ld_er   = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (pf_flt) begin
                    if (acc_act_i) begin
                        state_d = ST_GRACE;
                        ld_wp   = 1'b1;
                    end else begin
                        state_d = ST_PROT;
                    end
                end
            end
            ST_GRACE: begin
                if (!acc_act_i || tmr_zero) state_d = ST_PROT;
            end
            ST_PROT: begin
                if (so_flt && armed_q) begin
                    state_d = ST_BATT;
                end else if (!pf_flt) begin
                    state_d = ST_RECOV;
                    ld_er   = 1'b1;
                end
            end
            ST_BATT: begin
                if (!so_flt) state_d = ST_PROT;
            end
            ST_RECOV: begin
                if (pf_flt)        state_d = ST_PROT;
                else if (tmr_zero) state_d = ST_NORMAL;
            end
            default: state_d = ST_PROT;
        endcase
    end

    // Outputs, decoded from the current state.
    always_comb begin
        open_s     = pg_is_open(state_q);
        mem_ce_n_o = open_s ? host_ce_n_i : 1'b1;
        wr_prot_o  = !open_s;
        dq_hiz_o   = !open_s;
        bat_sel_o  = (state_q == ST_BATT);
    end
endmodule

// File: rtl/pwr_guard_chk.sv
`timescale 1ns/1ps
module pwr_guard_chk
    import pwr_guard_pkg::*;
#(
    parameter int WP_CYCLES = 16,
    parameter int ER_CYCLES = 40
) (
    input logic      clk,
    input logic      rst_n,
    input pg_state_e state_q,
    input logic      pf_flt,
    input logic      so_flt,
    input logic      acc_act_i,
    input logic      host_ce_n_i,
    input logic      mem_ce_n_o,
    input logic      wr_prot_o,
    input logic      dq_hiz_o,
    input logic      bat_sel_o
);
    localparam int GW = $clog2(WP_CYCLES + 2);
    localparam int RW = $clog2(ER_CYCLES + 2);

    logic [GW-1:0] grace_run;
    logic [RW-1:0] rec_run;
    logic          seen_good;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grace_run <= '0;
            rec_run   <= '0;
            seen_good <= 1'b0;
        end else begin
            grace_run <= (state_q == ST_GRACE) ? grace_run + 1'b1 : '0;
            rec_run   <= (state_q == ST_RECOV) ? rec_run + 1'b1 : '0;
            if (!pf_flt) seen_good <= 1'b1;
        end
    end

    a_r6_grace_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRACE) |-> (int'(grace_run) < WP_CYCLES))
        else $error("R6 grace window overran");

    a_r3_full_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && $past(state_q) == ST_RECOV) |-> (int'(rec_run) == ER_CYCLES))
        else $error("R3 recovery length wrong");

    a_r9_no_early_battery: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_good |-> !bat_sel_o)
        else $error("R9 battery selected before first power-up");

    a_r8_battery_needs_so: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel_o |-> $past(so_flt))
        else $error("R8 battery without switchover level");

    a_r7_deselect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot_o |-> (mem_ce_n_o && dq_hiz_o))
        else $error("R7 protected but memory reachable");

    a_r10_pf_blocks_normal: assert property (@(posedge clk) disable iff (!rst_n)
        pf_flt |=> (state_q != ST_NORMAL))
        else $error("R10 normal entered under power-fail");

    a_r5_grace_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRACE && !acc_act_i) |=> wr_prot_o)
        else $error("R5 grace did not end with access");

    a_r11_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_prot_o |-> (mem_ce_n_o == host_ce_n_i))
        else $error("R11 chip enable not passed through");
endmodule

bind pwr_guard pwr_guard_chk #(
    .WP_CYCLES (WP_CYCLES),
    .ER_CYCLES (ER_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .pf_flt      (pf_flt),
    .so_flt      (so_flt),
    .acc_act_i   (acc_act_i),
    .host_ce_n_i (host_ce_n_i),
    .mem_ce_n_o  (mem_ce_n_o),
    .wr_prot_o   (wr_prot_o),
    .dq_hiz_o    (dq_hiz_o),
    .bat_sel_o   (bat_sel_o)
);

// File: tb/test_pwr_guard.sv
`timescale 1ns/1ps
module test_pwr_guard;
    localparam int SYNC = 2;
    localparam int FILT = 3;
    localparam int WP   = 16;
    localparam int ER   = 40;

    logic clk = 1'b0;
    logic rst_n;
    logic warn, crit, host_ce_n, acc;
    logic mem_ce_n, wr_prot, dq_hiz, bat_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwr_guard #(
        .SYNC_STAGES (SYNC),
        .FILT_LEN    (FILT),
        .WP_CYCLES   (WP),
        .ER_CYCLES   (ER)
    ) i_pwr_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .vdd_warn_i  (warn),
        .vdd_crit_i  (crit),
        .host_ce_n_i (host_ce_n),
        .acc_act_i   (acc),
        .mem_ce_n_o  (mem_ce_n),
        .wr_prot_o   (wr_prot),
        .dq_hiz_o    (dq_hiz),
        .bat_sel_o   (bat_sel)
    );

    // Edges from a raw input change until the outputs follow it.
    function automatic int lat();
        return SYNC + FILT + 1;
    endfunction

    function automatic logic exp_ce(logic open_, logic host);
        return open_ ? host : 1'b1;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic power_up();
        @(negedge clk);
        warn = 1'b0;
        crit = 1'b0;
        edges(lat() + ER - 1);
        chk("R3 still locked", wr_prot, 1'b1);
        edges(1);
        chk("R3 released", wr_prot, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; warn = 1'b1; crit = 1'b1; host_ce_n = 1'b1; acc = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 wr_prot", wr_prot, 1'b1);
        chk("R1 dq_hiz", dq_hiz, 1'b1);
        chk("R1 mem_ce_n", mem_ce_n, 1'b1);
        chk("R1 bat_sel", bat_sel, 1'b0);

        // R9: switchover level present, no first power-up yet.
        for (int i = 0; i < 30; i++) begin
            edges(1);
            chk("R9 no battery before first power-up", bat_sel, 1'b0);
        end

        power_up();

        // R11: random host enables pass straight through.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            host_ce_n = 1'($urandom % 2);
            #1;
            chk("R11 pass-through", mem_ce_n, exp_ce(1'b1, host_ce_n));
            chk("R11 dq_hiz", dq_hiz, 1'b0);
        end
        @(negedge clk);
        host_ce_n = 1'b1;

        // R2: random glitches shorter than the filter are ignored.
        for (int i = 0; i < 8; i++) begin
            int w;
            w = 1 + int'($urandom % (FILT - 1));
            @(negedge clk);
            warn = 1'b1;
            repeat (w) @(negedge clk);
            warn = 1'b0;
            edges(lat() + 2 + int'($urandom % 4));
            chk("R2 short glitch ignored", wr_prot, 1'b0);
        end

        // R4 / R7: power-fail with no access.
        @(negedge clk);
        host_ce_n = 1'b0;
        warn = 1'b1;
        edges(lat() - 1);
        chk("R2 latency not yet", wr_prot, 1'b0);
        chk("R11 still open", mem_ce_n, 1'b0);
        edges(1);
        chk("R4 protected", wr_prot, 1'b1);
        chk("R7 ce gated", mem_ce_n, 1'b1);
        chk("R7 hiz", dq_hiz, 1'b1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            host_ce_n = 1'($urandom % 2);
            acc = 1'($urandom % 2);
            #1;
            chk("R7 inputs ignored", mem_ce_n, exp_ce(1'b0, host_ce_n));
        end
        @(negedge clk);
        host_ce_n = 1'b1;
        acc = 1'b0;

        // R8: battery in and out.
        @(negedge clk);
        crit = 1'b1;
        edges(lat() - 1);
        chk("R8 not yet battery", bat_sel, 1'b0);
        edges(1);
        chk("R8 battery", bat_sel, 1'b1);
        @(negedge clk);
        crit = 1'b0;
        edges(lat() - 1);
        chk("R8 battery held", bat_sel, 1'b1);
        edges(1);
        chk("R8 battery released", bat_sel, 1'b0);
        chk("R8 still protected", wr_prot, 1'b1);

        power_up();

        // R5: access in flight finishes early.
        @(negedge clk);
        acc = 1'b1;
        host_ce_n = 1'b0;
        warn = 1'b1;
        edges(lat());
        chk("R5 grace open", wr_prot, 1'b0);
        chk("R5 ce passes", mem_ce_n, 1'b0);
        edges(3);
        chk("R5 grace held", wr_prot, 1'b0);
        @(negedge clk);
        acc = 1'b0;
        host_ce_n = 1'b1;
        edges(1);
        chk("R5 access ended", wr_prot, 1'b1);

        power_up();

        // R6: access outlives the deadline.
        @(negedge clk);
        acc = 1'b1;
        host_ce_n = 1'b0;
        warn = 1'b1;
        edges(lat() + WP - 1);
        chk("R6 last grace cycle", wr_prot, 1'b0);
        edges(1);
        chk("R6 forced protect", wr_prot, 1'b1);
        chk("R6 ce forced off", mem_ce_n, 1'b1);
        @(negedge clk);
        acc = 1'b0;
        host_ce_n = 1'b1;

        // R10: power-fail during recovery.
        @(negedge clk);
        warn = 1'b0;
        edges(lat() + 10);
        chk("R10 in recovery", wr_prot, 1'b1);
        @(negedge clk);
        warn = 1'b1;
        for (int i = 0; i < lat() + 4; i++) begin
            edges(1);
            chk("R10 no normal", wr_prot, 1'b1);
        end
        @(negedge clk);
        warn = 1'b0;
        edges(lat() + ER - 1);
        chk("R10 full recovery again", wr_prot, 1'b1);
        edges(1);
        chk("R10 released", wr_prot, 1'b0);

        // R8 corner: both levels drop together from NORMAL.
        @(negedge clk);
        warn = 1'b1;
        crit = 1'b1;
        edges(lat());
        chk("R8 protect first", wr_prot, 1'b1);
        chk("R8 battery one edge later", bat_sel, 1'b0);
        edges(1);
        chk("R8 battery", bat_sel, 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule